// File: doc/BRIEF.md
# Interrupt Request Service Engine

This block sits between a bank of raw interrupt input pins and a downstream dispatcher. For each pin it applies a configurable polarity, keeps a pending bit, and for level-triggered pins a remote-pending flag. Each cycle it decides which pins are owed a delivery. The lowest-numbered pin that is owed one is offered to the dispatcher with its vector and trigger type. A same-cycle ready answer tells the engine whether the interrupt was actually taken.

Per-pin configuration comes from an external register table: mask, trigger type, polarity and vector. End-of-interrupt messages carry a vector number and a type. Every pin whose vector matches gets an acknowledge pulse. For a level-type message, every matching level-triggered pin also has its remote-pending flag released, so a still-active line is offered again. Edge pins fire once per rising effective level. A level pin that has been taken stays blocked until its end-of-interrupt arrives.

Top module: `irq_service_engine`

## Requirements
- R1: The effective level of pin i is `pin_level_i[i] XOR cfg_polarity_i[i]`. A polarity bit of 1 makes a low line active. Every later rule uses only the effective level.
- R2: A pin whose effective level is low has no pending request. A level pin that drops before being taken stops being offered on the next cycle.
- R3: An edge pin (`cfg_trig_level_i[i]`=0) is offered once after its effective level rises. The pending bit is consumed when the offer is made, whether or not the offer is accepted. Holding the line high does not offer the pin again.
- R4: A masked pin (`cfg_mask_i[i]`=1) is never offered. A rising edge seen while the pin is masked is discarded and is not delivered when the pin is later unmasked. A level pin that is active while masked is offered as soon as it is unmasked.
- R5: A level pin (`cfg_trig_level_i[i]`=1) with an active line is offered every cycle until the dispatcher accepts it. Once accepted, its remote-pending flag blocks further offers while the line stays active.
- R6: At most one pin is offered per cycle: the lowest-numbered pin owed a delivery. The others wait. `dlv_vector_o` carries that pin's vector and `dlv_level_o` carries its trigger type.
- R7: An end-of-interrupt with `eoi_level_i`=1 releases the remote-pending flag of every level pin whose vector equals `eoi_vector_i`. Each released pin that is still active and unmasked is offered from the next cycle.
- R8: An end-of-interrupt with `eoi_level_i`=0 releases no remote-pending flag.
- R9: In the cycle after an end-of-interrupt, `ack_o` holds a one-cycle bitmask with bit i set for every pin whose vector matches, whatever its trigger type. Otherwise `ack_o` is zero.
- R10: While reset is active there are no offers and `ack_o` is zero. After reset, no pin is pending or remote-pending.
- R11: If pin i's delivery is accepted in the same cycle that a level-type end-of-interrupt matches pin i, the remote-pending flag ends up set. An end-of-interrupt for another pin in that cycle still releases that other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level_i | input | NUM_PINS | Raw interrupt line levels |
| cfg_mask_i | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfg_polarity_i | input | NUM_PINS | Per-pin polarity, 1 = active low |
| cfg_trig_level_i | input | NUM_PINS | Per-pin trigger, 1 = level, 0 = edge |
| cfg_vector_i | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| eoi_valid_i | input | 1 | End-of-interrupt message strobe |
| eoi_vector_i | input | VEC_W | Vector carried by the message |
| eoi_level_i | input | 1 | Message type, 1 = level |
| dlv_valid_o | output | 1 | A delivery is offered this cycle |
| dlv_ready_i | input | 1 | Dispatcher took the offered delivery |
| dlv_pin_o | output | PIN_W | Pin number of the offer |
| dlv_vector_o | output | VEC_W | Vector of the offered pin |
| dlv_level_o | output | 1 | Trigger type of the offered pin |
| ack_o | output | NUM_PINS | Acknowledge pulses for matching pins |

## Verification
Two events can fall in the same cycle: an accepted delivery, which sets a remote-pending flag, and a level end-of-interrupt, which clears one. The bench provokes both cases. In the first, the message names the same pin that is being accepted. In the second, it names a different, already-blocked pin. The judgement rests on what the delivery port shows in the following cycles. If the same pin is not offered again, the set won. If the other pin is offered right after the lower pin's acceptance, its release took effect. The bench also overlaps a shared-vector end-of-interrupt with queued offers, to confirm that the acknowledge covers every matching pin while the lowest-first order is kept.

// File: rtl/ise_pkg.sv
package ise_pkg;
  // Per-pin tracking state
  typedef struct packed {
    logic pend;    // pending request
    logic lvl;     // effective level seen on previous cycle
    logic remote;  // delivered level interrupt awaiting end-of-interrupt
  } pin_state_t;
endpackage

// File: rtl/ise_pin_tracker.sv
module ise_pin_tracker
  import ise_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic eff_i,
  input  logic mask_i,
  input  logic level_trig_i,
  input  logic grant_i,
  input  logic accept_i,
  input  logic eoi_clr_i,
  output logic cand_o
);

  pin_state_t st_q;
  pin_state_t st_d;
  logic       st_en;

  always_comb begin
    st_d     = st_q;
    st_d.lvl = eff_i;
    if (level_trig_i) begin
      st_d.pend = eff_i;
    end else begin
      // edge: set on rise, consumed by an offer, discarded while masked
      st_d.pend = eff_i & ~mask_i & ((st_q.pend & ~grant_i) | ~st_q.lvl);
    end
    if (grant_i && accept_i && level_trig_i) begin
      st_d.remote = 1'b1;
    end else if (eoi_clr_i) begin
      st_d.remote = 1'b0;
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign cand_o = st_q.pend & ~mask_i & (~level_trig_i | ~st_q.remote);

endmodule

// File: rtl/ise_eoi_match.sv
module ise_eoi_match #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8
) (
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vector_i,
  input  logic [NUM_PINS*VEC_W-1:0] vec_flat_i,
  output logic [NUM_PINS-1:0]       hit_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
    assign hit_o[g] = eoi_valid_i && (vec_flat_i[g*VEC_W +: VEC_W] == eoi_vector_i);
  end

endmodule

// File: rtl/ise_prio_pick.sv
module ise_prio_pick #(
  parameter int N     = 24,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  // isolate lowest set bit
  assign gnt_o = req_i & (~req_i + {{(N-1){1'b0}}, 1'b1});
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[IW-1:0];
    end
  end

endmodule

// File: rtl/irq_service_engine.sv
module irq_service_engine
  import ise_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       pin_level_i,
  input  logic [NUM_PINS-1:0]       cfg_mask_i,
  input  logic [NUM_PINS-1:0]       cfg_polarity_i,
  input  logic [NUM_PINS-1:0]       cfg_trig_level_i,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector_i,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vector_i,
  input  logic                      eoi_level_i,
  output logic                      dlv_valid_o,
  input  logic                      dlv_ready_i,
  output logic [PIN_W-1:0]          dlv_pin_o,
  output logic [VEC_W-1:0]          dlv_vector_o,
  output logic                      dlv_level_o,
  output logic [NUM_PINS-1:0]       ack_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_PINS-1:0] eff;
  logic [NUM_PINS-1:0] cand;
  logic [NUM_PINS-1:0] gnt;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] eoi_clr;
  logic [PIN_W-1:0]    pick_idx;
  logic                pick_any;
  logic [VEC_W-1:0]    vec_arr [NUM_PINS];

  assign eff     = pin_level_i ^ cfg_polarity_i;
  assign eoi_clr = hit & cfg_trig_level_i & {NUM_PINS{eoi_level_i}};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign vec_arr[g] = cfg_vector_i[g*VEC_W +: VEC_W];

    ise_pin_tracker u_trk (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .eff_i        (eff[g]),
      .mask_i       (cfg_mask_i[g]),
      .level_trig_i (cfg_trig_level_i[g]),
      .grant_i      (gnt[g]),
      .accept_i     (dlv_ready_i),
      .eoi_clr_i    (eoi_clr[g]),
      .cand_o       (cand[g])
    );
  end

  ise_eoi_match #(
    .NUM_PINS (NUM_PINS),
    .VEC_W    (VEC_W)
  ) u_match (
    .eoi_valid_i  (eoi_valid_i),
    .eoi_vector_i (eoi_vector_i),
    .vec_flat_i   (cfg_vector_i),
    .hit_o        (hit)
  );

  ise_prio_pick #(
    .N (NUM_PINS)
  ) u_pick (
    .req_i (cand),
    .gnt_o (gnt),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  assign dlv_valid_o  = pick_any;
  assign dlv_pin_o    = pick_idx;
  assign dlv_vector_o = vec_arr[pick_idx];
  assign dlv_level_o  = cfg_trig_level_i[pick_idx];

  // acknowledge pulses
  logic [NUM_PINS-1:0] ack_q;
  logic [NUM_PINS-1:0] ack_d;
  logic                ack_en;

  assign ack_d  = hit;
  assign ack_en = (ack_d != ack_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_q <= '0;
    end else if (ack_en) begin
      ack_q <= ack_d;
    end
  end

  assign ack_o = ack_q;

endmodule

// File: rtl/ise_checker.sv
module ise_checker #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] cfg_mask_i,
  input logic                eoi_valid_i,
  input logic                dlv_valid_o,
  input logic                dlv_ready_i,
  input logic [PIN_W-1:0]    dlv_pin_o,
  input logic                dlv_level_o,
  input logic [NUM_PINS-1:0] ack_o
);

  assert_edge_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_o && !dlv_level_o) |=>
      !(dlv_valid_o && !dlv_level_o && dlv_pin_o == $past(dlv_pin_o)));

  assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid_o |-> !cfg_mask_i[dlv_pin_o]);

  assert_level_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_o && dlv_ready_i && dlv_level_o && !eoi_valid_i) |=>
      !(dlv_valid_o && dlv_pin_o == $past(dlv_pin_o)));

  assert_ack_follows_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |-> $past(eoi_valid_i));

endmodule

bind irq_service_engine ise_checker #(
  .NUM_PINS (NUM_PINS),
  .VEC_W    (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mask_i  (cfg_mask_i),
  .eoi_valid_i (eoi_valid_i),
  .dlv_valid_o (dlv_valid_o),
  .dlv_ready_i (dlv_ready_i),
  .dlv_pin_o   (dlv_pin_o),
  .dlv_level_o (dlv_level_o),
  .ack_o       (ack_o)
);

// File: tb/irq_service_engine_bench.sv
module irq_service_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 24;
  localparam int VW  = 8;
  localparam int PW  = $clog2(NP);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   act, pol, msk, trg;
  logic [NP-1:0]   pin_level;
  logic [VW-1:0]   vec [NP];
  logic [NP*VW-1:0] vec_flat;
  logic            eoi_valid, eoi_level, ready;
  logic [VW-1:0]   eoi_vector;
  logic            dlv_valid, dlv_level;
  logic [PW-1:0]   dlv_pin;
  logic [VW-1:0]   dlv_vector;
  logic [NP-1:0]   ack;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pin_level = act ^ pol;
  always_comb begin
    for (int i = 0; i < NP; i++) vec_flat[i*VW +: VW] = vec[i];
  end

  irq_service_engine #(.NUM_PINS(NP), .VEC_W(VW)) u_irq_service_engine (
    .clk(clk), .rst_n(rst_n), .pin_level_i(pin_level), .cfg_mask_i(msk),
    .cfg_polarity_i(pol), .cfg_trig_level_i(trg), .cfg_vector_i(vec_flat),
    .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector), .eoi_level_i(eoi_level),
    .dlv_valid_o(dlv_valid), .dlv_ready_i(ready), .dlv_pin_o(dlv_pin),
    .dlv_vector_o(dlv_vector), .dlv_level_o(dlv_level), .ack_o(ack)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [NP-1:0] exp_ack(input logic [VW-1:0] v);
    logic [NP-1:0] m = '0;
    for (int i = 0; i < NP; i++) if (vec[i] == v) m[i] = 1'b1;
    return m;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    act = '0; eoi_valid = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic send_eoi(input logic [VW-1:0] v, input logic lv);
    eoi_valid = 1'b1; eoi_vector = v; eoi_level = lv;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; act = '0; pol = '0; msk = '1; trg = '0; ready = 1'b0;
    eoi_valid = 1'b0; eoi_vector = '0; eoi_level = 1'b0;
    for (int i = 0; i < NP; i++) vec[i] = VW'(8'h20 + i);
    #2 rst_n = 1'b0;
    // R10: active unmasked level lines during reset produce nothing
    msk = '0; trg = '1; act = '1;
    tick(); tick();
    chk("R10 no offer in reset", dlv_valid, 0);
    chk("R10 ack zero in reset", ack, 0);
    act = '0;
    tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R10 idle after reset", dlv_valid, 0);

    // R1 / R3: edge sweep over every pin and both polarities
    trg = '0; ready = 1'b1;
    for (int p = 0; p < NP; p++) begin
      for (int pv = 0; pv < 2; pv++) begin
        pol[p] = pv[0]; act[p] = 1'b0;
        tick(); tick();
        chk("R1 inactive line idle", dlv_valid, 0);
        act[p] = 1'b1;
        tick();
        chk("R3 edge offered", dlv_valid, 1);
        chk("R6 offered pin", 32'(dlv_pin), p);
        chk("R6 offered vector", dlv_vector, 32'h20 + p);
        chk("R6 offered type edge", dlv_level, 0);
        tick();
        chk("R3 held high no refire", dlv_valid, 0);
        act[p] = 1'b0;
        tick();
      end
    end
    pol = '0;
    // R3: unaccepted edge offer is still consumed
    ready = 1'b0; act[11] = 1'b1;
    tick();
    chk("R3 edge offered pin11", 32'(dlv_pin), 11);
    tick();
    chk("R3 consumed without accept", dlv_valid, 0);
    act[11] = 1'b0; ready = 1'b1;
    tick();

    // R5 / R7 / R9 / R2: level sweep
    do_reset();
    trg = '1;
    for (int p = 0; p < NP; p++) begin
      ready = 1'b0; act[p] = 1'b1;
      tick();
      chk("R5 level offered", dlv_valid, 1);
      chk("R6 level pin", 32'(dlv_pin), p);
      chk("R6 offered type level", dlv_level, 1);
      tick();
      chk("R5 retried until accepted", dlv_valid, 1);
      ready = 1'b1;
      tick();
      chk("R5 blocked after accept", dlv_valid, 0);
      tick();
      chk("R5 still blocked", dlv_valid, 0);
      send_eoi(vec[p], 1'b1);
      tick();
      eoi_valid = 1'b0;
      chk("R9 ack mask", ack, exp_ack(vec[p]));
      chk("R7 re-offered after eoi", dlv_valid, 1);
      tick();
      chk("R5 accepted again", dlv_valid, 0);
      chk("R9 ack one cycle", ack, 0);
      act[p] = 1'b0;
      send_eoi(vec[p], 1'b1);
      tick();
      eoi_valid = 1'b0;
      chk("R2 low line not offered", dlv_valid, 0);
      tick();
    end
    // R2: level line dropping before being taken
    ready = 1'b0; act[6] = 1'b1;
    tick();
    chk("R2 offered before drop", dlv_valid, 1);
    act[6] = 1'b0;
    tick();
    chk("R2 withdrawn after drop", dlv_valid, 0);

    // R6 / R7: priority and shared-vector release
    do_reset();
    trg = '1; ready = 1'b1;
    vec[3] = 8'h55; vec[7] = 8'h55; vec[15] = 8'h55;
    act = (NP'(1) << 3) | (NP'(1) << 7) | (NP'(1) << 15);
    tick();
    chk("R6 lowest first", 32'(dlv_pin), 3);
    tick();
    chk("R6 second", 32'(dlv_pin), 7);
    tick();
    chk("R6 third", 32'(dlv_pin), 15);
    tick();
    chk("R6 all taken", dlv_valid, 0);
    send_eoi(8'h55, 1'b1);
    tick();
    eoi_valid = 1'b0;
    chk("R9 shared vector ack", ack, exp_ack(8'h55));
    chk("R7 all released lowest first", 32'(dlv_pin), 3);
    tick();
    chk("R7 second released", 32'(dlv_pin), 7);
    tick();
    chk("R7 third released", 32'(dlv_pin), 15);
    tick();
    chk("R7 drained", dlv_valid, 0);
    for (int i = 0; i < NP; i++) vec[i] = VW'(8'h20 + i);

    // R4: masking
    do_reset();
    trg = '0; msk[5] = 1'b1; act[5] = 1'b1;
    tick();
    chk("R4 masked edge silent", dlv_valid, 0);
    tick();
    msk[5] = 1'b0;
    tick();
    chk("R4 masked edge discarded", dlv_valid, 0);
    act[5] = 1'b0;
    trg[9] = 1'b1; msk[9] = 1'b1; act[9] = 1'b1;
    tick();
    chk("R4 masked level silent", dlv_valid, 0);
    msk[9] = 1'b0;
    #1;
    chk("R4 unmasked level offered", dlv_valid, 1);
    chk("R4 unmasked level pin", 32'(dlv_pin), 9);

    // R8: edge-type end-of-interrupt
    do_reset();
    trg = '1; ready = 1'b1; act[2] = 1'b1;
    tick();
    chk("R8 setup offer", dlv_valid, 1);
    tick();
    chk("R8 setup blocked", dlv_valid, 0);
    send_eoi(vec[2], 1'b0);
    tick();
    eoi_valid = 1'b0;
    chk("R9 ack on edge-type eoi", ack, exp_ack(vec[2]));
    chk("R8 no release", dlv_valid, 0);
    send_eoi(vec[2], 1'b1);
    tick();
    eoi_valid = 1'b0;
    chk("R7 level eoi releases", dlv_valid, 1);

    // R11: accept and release in the same cycle
    do_reset();
    trg = '1; ready = 1'b1; act[4] = 1'b1;
    tick();
    chk("R11 setup offer", 32'(dlv_pin), 4);
    send_eoi(vec[4], 1'b1);
    tick();
    eoi_valid = 1'b0;
    chk("R11 accept wins over release", dlv_valid, 0);
    chk("R11 ack", ack, exp_ack(vec[4]));
    tick();
    chk("R11 stays blocked", dlv_valid, 0);
    act[4] = 1'b0;
    send_eoi(vec[4], 1'b1);
    tick();
    eoi_valid = 1'b0;
    act[6] = 1'b1;
    tick();
    tick();
    chk("R11 pin6 blocked", dlv_valid, 0);
    act[4] = 1'b1;
    tick();
    chk("R11 pin4 offered", 32'(dlv_pin), 4);
    send_eoi(vec[6], 1'b1);
    tick();
    eoi_valid = 1'b0;
    chk("R11 other pin released", dlv_valid, 1);
    chk("R11 other pin number", 32'(dlv_pin), 6);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule